// File: doc/BRIEF.md
# Programmable Interrupt Hub

The interrupt hub collects 32 interrupt request lines and presents them to a processor through a small word-addressed register port and two request outputs. Each line is first brought into the clock domain through two flip-flops. Then, according to its own trigger and polarity bits, it is sensed as a rising edge, a falling edge, an active-high level or an active-low level. A sensed event sets a sticky status bit. Software removes a status bit by writing a one to it.

Each status bit is gated by an enable bit. The gated bits form the masked-status word, which drives two outputs: a critical request and a normal request. A per-source critical-select bit chooses which of the two a source feeds. The hub also reports which pending, enabled source should be serviced next, so the handler does not have to scan the masked word itself. A second hub can be stacked below this one by wiring its normal output into one of this hub's inputs.

Every per-source register uses the same bit order, with source n at bit 31−n. Source 0 is therefore the most significant bit, and when several sources are pending the higher-numbered source is serviced first.

Top module: `irq_hub`

## Requirements
- R1: Input `irq_in[n]` (source n) appears at bit 31−n of the status, enable, critical-select, polarity, trigger and masked-status words.
- R2: While reset is held and after reset, the status, enable, critical-select, polarity and trigger registers read zero, and both request outputs are low.
- R3: A change on an input line is visible in the status word after the third rising clock edge that follows it, and not after the second.
- R4: With trigger bit 0 (level), a source sets its status bit on every cycle in which its synchronised input equals its polarity bit (1 = active high, 0 = active low). The reset defaults therefore make a low input pending.
- R5: With trigger bit 1 (edge), polarity 1 sets status on a 0→1 transition and polarity 0 sets it on a 1→0 transition. The opposite transition has no effect, and the bit stays set after the input returns.
- R6: A write to offset 0x0 clears each status bit written as 1 and leaves the bits written as 0 unchanged. When a set event and a clear fall in the same cycle, the set wins.
- R7: Clearing a level-sensed source whose input is still at its active level leaves the status bit at 1, whether or not the source is enabled.
- R8: Status bits are set independently of the enable register. An edge on a disabled source is still recorded.
- R9: Offset 0x6 reads the bitwise AND of status and enable. It reads zero when no enabled source is pending.
- R10: `irq_crit` is high when some masked-status bit has its critical-select bit at 1. `irq_norm` is high when some masked-status bit has its critical-select bit at 0. Both outputs are low when enable is all zero.
- R11: Offset 0x7 reads the service pick. Bits 4:0 hold 31 minus the index of the lowest set masked-status bit, which is the highest-numbered pending source. Bit 8 is 1 when any masked bit is set. The word reads all zero when no masked bit is set.
- R12: Enable (0x2), critical select (0x3), polarity (0x4) and trigger (0x5) are read/write. Offsets 0x1 and 0x8 to 0xF read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Raw request lines, index = source number |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_norm | output | 1 | Normal-class request |
| irq_crit | output | 1 | Critical-class request |

## Verification
The in-line properties are checked on every cycle. They cover three groups of behaviour:
- Status: every sensed event sets its status bit in the next cycle, and a clear with no coinciding event drops the bit. A clear on a level source whose input is still active cannot drop it.
- Service pick: it always names the lowest set masked bit, and it is invalid only when nothing is masked.
- Configuration: the request outputs stay quiet when everything is disabled, and writes to unused offsets leave the configuration untouched.

Some behaviour is shown only by the bench scenarios, which read the register port:
- the reversed bit mapping from `irq_in` to register bits;
- the exact three-edge input latency;
- the difference between rising and falling sensing;
- the reset default in which a low input counts as pending;
- partial write-one-to-clear patterns;
- the split of requests between the critical and normal outputs.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int OFF_W = 4;

    localparam logic [OFF_W-1:0] OFF_STAT = 4'h0;
    localparam logic [OFF_W-1:0] OFF_EN   = 4'h2;
    localparam logic [OFF_W-1:0] OFF_CRIT = 4'h3;
    localparam logic [OFF_W-1:0] OFF_POL  = 4'h4;
    localparam logic [OFF_W-1:0] OFF_TRIG = 4'h5;
    localparam logic [OFF_W-1:0] OFF_MASK = 4'h6;
    localparam logic [OFF_W-1:0] OFF_VEC  = 4'h7;

    // position of the "pick valid" flag in the vector word
    localparam int VEC_VLD_BIT = 8;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/irq_hub_sense.sv
module irq_hub_sense #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,      // synchronised inputs, register bit order
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trig,
    input  logic         clr_we,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } sense_t;

    sense_t st_d, st_q;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (trig[i]) begin
                hit[i] = pol[i] ? (lvl[i] & ~st_q.prev[i]) : (~lvl[i] & st_q.prev[i]);
            end else begin
                hit[i] = ~(lvl[i] ^ pol[i]);
            end
        end

        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> status[i]);                                        // R5
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr[i] && !hit[i]) |=> !status[i]);                 // R6
        AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr[i] && !trig[i] && (lvl[i] == pol[i])) |=> status[i]); // R7
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.stat = (st_q.stat & ~(clr_we ? clr : '0)) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;

endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     masked,
    output logic [IDX_W-1:0] num,
    output logic             vld
);
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     below;

    // scan downward so the lowest set bit is the last to assign
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (masked[i]) idx = IDX_W'(i);
        end
    end

    assign vld   = |masked;
    assign num   = vld ? (IDX_W'(W - 1) - idx) : '0;
    assign below = (W'(1) << idx) - W'(1);

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (masked[idx] && ((masked & below) == '0)));              // R11
    AST_PICK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (masked == '0 && num == '0));                           // R11

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic             reg_we,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    output logic             irq_norm,
    output logic             irq_crit
);
    localparam int IDX_W = $clog2(N_SRC);

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] crit;
        logic [N_SRC-1:0] pol;
        logic [N_SRC-1:0] trig;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_SRC-1:0] src_bits;
    logic [N_SRC-1:0] lvl;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] masked;
    logic [IDX_W-1:0] pick_num;
    logic             pick_vld;
    logic             stat_clr;
    logic             gap_wr;

    // source n lands on register bit N_SRC-1-n
    for (genvar n = 0; n < N_SRC; n++) begin : g_map
        assign src_bits[N_SRC-1-n] = irq_in[n];
    end

    irq_hub_sync #(.W(N_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src_bits),
        .dout (lvl)
    );

    assign stat_clr = reg_we && (reg_addr == OFF_STAT);

    irq_hub_sense #(.W(N_SRC)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .pol   (cfg_q.pol),
        .trig  (cfg_q.trig),
        .clr_we(stat_clr),
        .clr   (reg_wdata),
        .status(status)
    );

    assign masked = status & cfg_q.en;

    irq_hub_pick #(.W(N_SRC), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .masked(masked),
        .num   (pick_num),
        .vld   (pick_vld)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_addr)
                OFF_EN:   cfg_d.en   = reg_wdata;
                OFF_CRIT: cfg_d.crit = reg_wdata;
                OFF_POL:  cfg_d.pol  = reg_wdata;
                OFF_TRIG: cfg_d.trig = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_STAT: reg_rdata = status;
            OFF_EN:   reg_rdata = cfg_q.en;
            OFF_CRIT: reg_rdata = cfg_q.crit;
            OFF_POL:  reg_rdata = cfg_q.pol;
            OFF_TRIG: reg_rdata = cfg_q.trig;
            OFF_MASK: reg_rdata = masked;
            OFF_VEC: begin
                reg_rdata[IDX_W-1:0]  = pick_num;
                reg_rdata[VEC_VLD_BIT] = pick_vld;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_crit = |(masked & cfg_q.crit);
    assign irq_norm = |(masked & ~cfg_q.crit);

    assign gap_wr = reg_we && (reg_addr == 4'h1 || reg_addr > OFF_VEC);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));                                  // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.en == '0) |-> (!irq_norm && !irq_crit));                    // R10
    AST_REQ_HAS_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm || irq_crit) |-> pick_vld);                              // R10
    AST_GAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        gap_wr |=> (cfg_q == $past(cfg_q)));                               // R12

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_norm, irq_crit;

    always #4 clk = ~clk;   // 125 MHz

    irq_hub uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 normal out, 2 critical out
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    function automatic logic [31:0] sbit(input int n);
        return 32'h1 << (31 - n);
    endfunction

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() > 0);
            it  = sb.pop_front();
            act = (it.kind == 0) ? reg_rdata :
                  (it.kind == 1) ? {31'b0, irq_norm} : {31'b0, irq_crit};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [3:0] a, input logic [31:0] e, input string r);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        #2;
        it.kind = kind; it.exp = e; it.req = r;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    initial begin
        // R2: reset state
        tick(2);
        chk(0, 4'h0, 32'h0, "R2 status in reset");
        chk(0, 4'h2, 32'h0, "R2 enable in reset");
        chk(0, 4'h3, 32'h0, "R2 crit in reset");
        chk(0, 4'h4, 32'h0, "R2 polarity in reset");
        chk(0, 4'h5, 32'h0, "R2 trigger in reset");
        chk(1, 4'h0, 32'h0, "R2 normal out in reset");
        chk(2, 4'h0, 32'h0, "R2 crit out in reset");
        @(negedge clk) rst_n = 1'b1;
        tick(4);
        chk(0, 4'h0, 32'hFFFF_FFFF, "R4 default active-low level");

        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, 32'hFFFF_FFFF);
        chk(0, 4'h0, 32'h0, "R6 clear all");

        // R1 R3 R4: source 3 level high -> bit 28
        @(negedge clk) irq_in[3] = 1'b1;
        tick(1);
        chk(0, 4'h0, 32'h0, "R3 not after two edges");
        chk(0, 4'h0, sbit(3), "R3 R1 set after three edges");

        // R7: clearing active level while disabled
        wr(4'h0, sbit(3));
        chk(0, 4'h0, sbit(3), "R7 level clear ignored");
        @(negedge clk) irq_in[3] = 1'b0;
        tick(4);
        chk(0, 4'h0, sbit(3), "R4 status sticky after release");
        wr(4'h0, sbit(3));
        chk(0, 4'h0, 32'h0, "R6 clear after release");

        // R5 R8: rising edges on disabled sources 5 and 20
        wr(4'h5, sbit(5) | sbit(20));
        @(negedge clk) begin irq_in[5] = 1'b1; irq_in[20] = 1'b1; end
        tick(4);
        @(negedge clk) begin irq_in[5] = 1'b0; irq_in[20] = 1'b0; end
        tick(4);
        chk(0, 4'h0, sbit(5) | sbit(20), "R5 R8 edge latched while disabled");
        wr(4'h0, sbit(5));
        chk(0, 4'h0, sbit(20), "R6 partial clear");

        // R5: falling edge on source 20
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h4, ~sbit(20));
        @(negedge clk) irq_in[20] = 1'b1;
        tick(4);
        chk(0, 4'h0, 32'h0, "R5 rising ignored for falling mode");
        @(negedge clk) irq_in[20] = 1'b0;
        tick(4);
        chk(0, 4'h0, sbit(20), "R5 falling edge sets");

        // R9 R10 R11
        @(negedge clk) irq_in[5] = 1'b1;
        tick(4);
        @(negedge clk) irq_in[5] = 1'b0;
        tick(1);
        chk(0, 4'h0, sbit(5) | sbit(20), "R5 status two edges");
        wr(4'h2, sbit(20));
        chk(0, 4'h6, sbit(20), "R9 masked one enabled");
        chk(1, 4'h0, 32'h1, "R10 normal high");
        chk(2, 4'h0, 32'h0, "R10 crit low");
        chk(0, 4'h7, 32'h0000_0114, "R11 pick source 20");
        wr(4'h2, sbit(5) | sbit(20));
        chk(0, 4'h6, sbit(5) | sbit(20), "R9 masked both");
        chk(0, 4'h7, 32'h0000_0114, "R11 higher number wins");
        wr(4'h3, sbit(20));
        chk(1, 4'h0, 32'h1, "R10 normal from source 5");
        chk(2, 4'h0, 32'h1, "R10 crit from source 20");
        wr(4'h3, sbit(5) | sbit(20));
        chk(1, 4'h0, 32'h0, "R10 normal low all crit");
        chk(2, 4'h0, 32'h1, "R10 crit high");
        chk(0, 4'h3, sbit(5) | sbit(20), "R12 crit readback");
        wr(4'h2, 32'h0);
        chk(1, 4'h0, 32'h0, "R10 normal off when disabled");
        chk(2, 4'h0, 32'h0, "R10 crit off when disabled");
        chk(0, 4'h6, 32'h0, "R9 masked zero");
        chk(0, 4'h7, 32'h0, "R11 no pick");

        // R12: gap offsets
        wr(4'h1, 32'hFFFF_FFFF);
        chk(0, 4'h1, 32'h0, "R12 offset 1 reads zero");
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hF, 32'hFFFF_FFFF);
        chk(0, 4'h8, 32'h0, "R12 offset 8 reads zero");
        chk(0, 4'hF, 32'h0, "R12 offset F reads zero");
        chk(0, 4'h2, 32'h0, "R12 enable untouched");
        chk(0, 4'h5, sbit(5) | sbit(20), "R12 trigger untouched");
        chk(0, 4'h4, ~sbit(20), "R12 polarity untouched");

        // R1: source 0 at the MSB
        @(negedge clk) irq_in[0] = 1'b1;
        wr(4'h2, sbit(0));
        tick(3);
        chk(0, 4'h0, sbit(0) | sbit(5) | sbit(20), "R1 source 0 at bit 31");
        chk(0, 4'h6, 32'h8000_0000, "R1 masked MSB");
        chk(0, 4'h7, 32'h0000_0100, "R11 pick source 0");
        chk(1, 4'h0, 32'h1, "R10 normal from source 0");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule